// File: doc/BRIEF.md
# Chainable Serial Register Slave

This block is the configuration front end of a multichannel continuous-wave waveform generator. A host writes and reads a small bank of registers over a four-wire serial link: one delay byte per channel, a shared frequency divider byte, and a per-channel output high-impedance mask. Each transfer is a 13-bit word, most significant bit first. The top bit says write (1) or read (0), the next four bits select a register, and the low eight bits carry data. The register contents go out on parallel ports that feed the waveform generator directly.

Several copies can share one chip select and serial clock, each serial output wired to the next serial input. The host then shifts one word per device before raising chip select, and every device acts on the word left in its own shift register. With the broadcast input high, serial input goes straight to serial output, so every device in the chain captures the same word in one 13-bit transfer. Writes are held off while the transmit-run input is high. All pins are sampled by the system clock through synchronizers, so the serial clock must be several times slower than the system clock.

Top module: `chain_reg_slave`

## Requirements
- R1: After reset every delay, divider and mask register reads zero on the output ports and the serial output is 0.
- R2: A word whose top bit is 1 changes the addressed register only after chip select rises; while chip select is still low the register keeps its old value.
- R3: Address values 0 to NCH-1 select the channel delay registers in channel order, address NCH (8 by default) selects the divider, address NCH+1 (9 by default) selects the high-impedance mask, whose bit n belongs to channel n.
- R4: A write to any other address changes no register, and a read of such an address returns data 0.
- R5: A word whose top bit is 0 changes no register; on chip select rising the shift register is loaded with {0, the 4-bit address, the addressed register's 8-bit value}, and these 13 bits leave on the serial output MSB first, the first bit visible before the first serial clock rising edge of the next transfer and each further bit after each rising edge.
- R6: While transmit-run is high, a write word is ignored and every register keeps its value; writes work again once it is low.
- R7: Serial data is sampled on the serial clock rising edge while chip select is low, and the serial output outside broadcast is the bit shifted in 13 rising edges earlier, so two chained devices receive separate words from one 26-bit transfer and return their read words in the same order.
- R8: While broadcast is high the serial output follows the serial input directly, and every device of a chain commits the same 13-bit word.
- R9: A transfer of any length commits the last 13 bits held in the shift register when chip select rises, including bits left from the previous word after a short transfer.
- R10: Serial clock edges while chip select is high do not shift the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, data sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| bcast | input | 1 | Broadcast: route sdi straight to sdo |
| txrun | input | 1 | Transmit running: blocks register writes |
| sdo | output | 1 | Serial data out, to the next device or the host |
| delay_o | output | NCH*DW | Channel delay registers, channel n at bits n*DW +: DW |
| div_o | output | DW | Frequency divider register |
| hiz_o | output | NCH | High-impedance mask, one bit per channel |

## Verification
The bench aims at the moment of commit: it checks a register before and after chip select rises, so a design that wrote on the last serial edge would be caught. It shortens and lengthens transfers to expose a design that counts bits or clears the shift register between words, pulses the serial clock with chip select high to catch a shifter that ignores select, and reads back unmapped addresses to catch aliasing onto real registers. Two chained instances are driven with 26-bit transfers and in broadcast mode, where a wrong tap of the serial output would swap or duplicate the two devices' words, and writes under transmit-run show whether the lockout is honoured.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [1:0] {
    RK_DELAY,
    RK_DIVIDER,
    RK_MASK,
    RK_NONE
  } reg_kind_e;

  // Total frame length: direction flag, address, data.
  function automatic int frame_width(input int aw, input int dw);
    return 1 + aw + dw;
  endfunction

  // Register map: channels first, then divider, then mask.
  function automatic reg_kind_e kind_of(input int unsigned addr, input int nch);
    if (addr < nch)          return RK_DELAY;
    else if (addr == nch)    return RK_DIVIDER;
    else if (addr == nch + 1) return RK_MASK;
    else                     return RK_NONE;
  endfunction

endpackage

// File: rtl/crs_pin_sync.sv
module crs_pin_sync #(
  parameter int            N       = 4,
  parameter int            STAGES  = 2,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [STAGES-1:0][N-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{RST_VAL}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/crs_shifter.sv
module crs_shifter #(
  parameter int FW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  input  logic          load_en,
  input  logic [FW-1:0] load_val,
  output logic [FW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {q[FW-2:0], din};
  end

endmodule

// File: rtl/crs_regbank.sv
module crs_regbank
  import crs_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NCH*DW-1:0] delay_o,
  output logic [DW-1:0]     div_o,
  output logic [NCH-1:0]    mask_o
);

  reg_kind_e wr_kind, rd_kind;
  assign wr_kind = kind_of(int'(wr_addr), NCH);
  assign rd_kind = kind_of(int'(rd_addr), NCH);

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_delay
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          delay_o[ch*DW +: DW] <= '0;
        else if (wr_en && wr_kind == RK_DELAY && int'(wr_addr) == ch)
          delay_o[ch*DW +: DW] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_o  <= '0;
      mask_o <= '0;
    end else if (wr_en) begin
      if (wr_kind == RK_DIVIDER) div_o  <= wr_data;
      if (wr_kind == RK_MASK)    mask_o <= wr_data[NCH-1:0];
    end
  end

  always_comb begin
    unique case (rd_kind)
      RK_DELAY:   rd_data = delay_o[int'(rd_addr)*DW +: DW];
      RK_DIVIDER: rd_data = div_o;
      RK_MASK:    rd_data = DW'(mask_o);
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/chain_reg_slave.sv
module chain_reg_slave
  import crs_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              bcast,
  input  logic              txrun,
  output logic              sdo,
  output logic [NCH*DW-1:0] delay_o,
  output logic [DW-1:0]     div_o,
  output logic [NCH-1:0]    hiz_o
);

  localparam int FW = frame_width(AW, DW);
  localparam logic [3:0] PIN_RST = 4'b0001;   // chip select idles high

  // Synchronized pins: {txrun, sdi, sck, cs_n}
  logic [3:0] pins_s;
  logic       cs_s, sck_s, sdi_s, txrun_s;
  logic       cs_prev, sck_prev;

  crs_pin_sync #(.N(4), .STAGES(STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({txrun, sdi, sck, cs_n}),
    .q     (pins_s)
  );

  assign cs_s    = pins_s[0];
  assign sck_s   = pins_s[1];
  assign sdi_s   = pins_s[2];
  assign txrun_s = pins_s[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_s;
      sck_prev <= sck_s;
    end
  end

  // Named events for the checker
  logic cs_rise, sck_rise, wr_commit, rd_fetch;
  assign cs_rise  = cs_s & ~cs_prev;
  assign sck_rise = sck_s & ~sck_prev & ~cs_s;

  // Frame fields
  logic [FW-1:0] sh_q;
  logic          fr_write;
  logic [AW-1:0] fr_addr;
  logic [DW-1:0] fr_data;
  logic [DW-1:0] rd_data;
  logic [FW-1:0] rd_word;

  assign fr_write  = sh_q[FW-1];
  assign fr_addr   = sh_q[FW-2:DW];
  assign fr_data   = sh_q[DW-1:0];
  assign wr_commit = cs_rise & fr_write & ~txrun_s;
  assign rd_fetch  = cs_rise & ~fr_write;
  assign rd_word   = {1'b0, fr_addr, rd_data};

  crs_shifter #(.FW(FW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sck_rise),
    .din      (sdi_s),
    .load_en  (rd_fetch),
    .load_val (rd_word),
    .q        (sh_q)
  );

  crs_regbank #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_commit),
    .wr_addr (fr_addr),
    .wr_data (fr_data),
    .rd_addr (fr_addr),
    .rd_data (rd_data),
    .delay_o (delay_o),
    .div_o   (div_o),
    .mask_o  (hiz_o)
  );

  // Broadcast bypasses the shift register entirely.
  assign sdo = bcast ? sdi : sh_q[FW-1];

endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int FW  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              cs_rise,
  input logic              sck_rise,
  input logic              sdi_s,
  input logic              txrun_s,
  input logic              rd_fetch,
  input logic [FW-1:0]     sh_q,
  input logic [NCH*DW-1:0] delay_o,
  input logic [DW-1:0]     div_o,
  input logic [NCH-1:0]    hiz_o
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (delay_o == '0 && div_o == '0 && hiz_o == '0 && sh_q == '0)); // R1

  AST_CHANGE_ON_CS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(delay_o) || !$stable(div_o) || !$stable(hiz_o)) |-> $past(cs_rise)); // R2

  AST_READ_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fetch |=> (sh_q[FW-1] == 1'b0 && sh_q[FW-2:DW] == $past(sh_q[FW-2:DW]))); // R5

  AST_RUN_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (txrun_s && cs_rise) |=> ($stable(delay_o) && $stable(div_o) && $stable(hiz_o))); // R6

  AST_SHIFT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> sh_q[0] == $past(sdi_s)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !cs_rise) |=> $stable(sh_q)); // R10

endmodule

bind chain_reg_slave crs_checker #(.NCH(NCH), .DW(DW), .FW(FW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_s     (cs_s),
  .cs_rise  (cs_rise),
  .sck_rise (sck_rise),
  .sdi_s    (sdi_s),
  .txrun_s  (txrun_s),
  .rd_fetch (rd_fetch),
  .sh_q     (sh_q),
  .delay_o  (delay_o),
  .div_o    (div_o),
  .hiz_o    (hiz_o)
);

// File: tb/chain_reg_slave_bench.sv
module chain_reg_slave_bench;

  localparam int HALF = 8;   // system clocks per serial clock half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, bcast = 1'b0, txrun = 1'b0;
  logic sdo0, sdo1;
  logic [63:0] d0_delay, d1_delay;
  logic [7:0]  d0_div, d1_div, d0_hiz, d1_hiz;

  always #4 clk = ~clk;   // 125 MHz

  chain_reg_slave u_chain_reg_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .bcast(bcast), .txrun(txrun), .sdo(sdo0),
    .delay_o(d0_delay), .div_o(d0_div), .hiz_o(d0_hiz)
  );

  chain_reg_slave u_chain_reg_slave_next (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdo0),
    .bcast(bcast), .txrun(txrun), .sdo(sdo1),
    .delay_o(d1_delay), .div_o(d1_div), .hiz_o(d1_hiz)
  );

  // Scoreboard
  typedef struct {
    int          req;
    int          dev;
    int          fld;   // 0..7 delay, 8 divider, 9 mask, 10 read word, 11 sdo
    logic [15:0] exp;
  } item_t;

  item_t sbq[$];
  event  chk_ev;
  int    total = 0, bad = 0;
  logic  finished = 1'b0;
  logic [12:0] rdw0, rdw1;
  logic [63:0] got0, got1;
  logic [7:0]  m0 [10];

  function automatic logic [15:0] obs(input int dev, input int fld);
    if (fld < 8)        return 16'(dev ? d1_delay[fld*8 +: 8] : d0_delay[fld*8 +: 8]);
    else if (fld == 8)  return 16'(dev ? d1_div : d0_div);
    else if (fld == 9)  return 16'(dev ? d1_hiz : d0_hiz);
    else if (fld == 10) return 16'(dev ? rdw1 : rdw0);
    else                return 16'(dev ? sdo1 : sdo0);
  endfunction

  function automatic logic [12:0] fr(input logic w, input logic [3:0] a, input logic [7:0] d);
    return {w, a, d};
  endfunction

  task automatic expect_item(input int req, input int dev, input int fld, input logic [15:0] v);
    item_t it;
    it.req = req; it.dev = dev; it.fld = fld; it.exp = v;
    sbq.push_back(it);
  endtask

  task automatic expect_model(input int req);
    for (int f = 0; f < 10; f++) expect_item(req, 0, f, 16'(m0[f]));
  endtask

  task automatic flush;
    -> chk_ev;
    @(negedge clk);
  endtask

  initial begin : monitor
    item_t it;
    logic [15:0] o;
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        o = obs(it.dev, it.fld);
        total++;
        if (o !== it.exp) begin
          bad++;
          $display("FAIL R%0d dev%0d field%0d actual=%h expected=%h", it.req, it.dev, it.fld, o, it.exp);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_shift(input logic [63:0] bits, input int n);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(HALF);
      got0 = {got0[62:0], sdo0};
      got1 = {got1[62:0], sdo1};
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    sdi = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_release;
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    spi_shift(64'(fr(1'b1, a, d)), 13);
    cs_release();
  endtask

  task automatic read_reg(input logic [3:0] a);
    spi_shift(64'(fr(1'b0, a, 8'h00)), 13);
    cs_release();
    spi_shift(64'h0, 13);
    cs_release();
    rdw0 = got0[12:0];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 10; i++) m0[i] = 8'h00;
    rdw0 = '0; rdw1 = '0; got0 = '0; got1 = '0;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(4);

    // R1: reset state on both devices
    expect_model(1);
    for (int f = 0; f < 10; f++) expect_item(1, 1, f, 16'h0);
    expect_item(1, 0, 11, 16'h0);
    expect_item(1, 1, 11, 16'h0);
    flush();

    // R2: nothing changes until chip select rises
    spi_shift(64'(fr(1'b1, 4'h3, 8'h55)), 13);
    expect_item(2, 0, 3, 16'h00);
    flush();
    cs_release();
    m0[3] = 8'h55;
    expect_item(2, 0, 3, 16'h55);
    flush();

    // R3: full map, channel order, divider at 8, mask at 9
    for (int ch = 0; ch < 8; ch++) begin
      write_reg(4'(ch), 8'(8'h10 + ch * 8'h11));
      m0[ch] = 8'(8'h10 + ch * 8'h11);
    end
    write_reg(4'h8, 8'h2A); m0[8] = 8'h2A;
    write_reg(4'h9, 8'h81); m0[9] = 8'h81;
    expect_model(3);
    flush();

    // R4: unmapped writes ignored, unmapped reads return zero data
    write_reg(4'hA, 8'hFF);
    write_reg(4'hF, 8'hFF);
    expect_model(4);
    flush();
    read_reg(4'hC);
    expect_item(4, 0, 10, 16'(fr(1'b0, 4'hC, 8'h00)));
    flush();

    // R5: read echoes address and value, registers untouched
    read_reg(4'h3);
    expect_item(5, 0, 10, 16'(fr(1'b0, 4'h3, m0[3])));
    expect_model(5);
    flush();
    read_reg(4'h9);
    expect_item(5, 0, 10, 16'(fr(1'b0, 4'h9, m0[9])));
    flush();

    // R10: serial clock pulses with select high leave the fetched word intact
    spi_shift(64'(fr(1'b0, 4'h8, 8'h00)), 13);
    cs_release();
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sck = 1'b1; wait_clk(HALF);
      sck = 1'b0; wait_clk(HALF);
    end
    sdi = 1'b0;
    spi_shift(64'h0, 13);
    cs_release();
    rdw0 = got0[12:0];
    expect_item(10, 0, 10, 16'(fr(1'b0, 4'h8, m0[8])));
    flush();

    // R6: transmit-run blocks writes, release restores them
    txrun = 1'b1;
    write_reg(4'h0, 8'hEE);
    write_reg(4'h9, 8'h00);
    txrun = 1'b0;
    wait_clk(4);
    expect_model(6);
    flush();
    write_reg(4'h0, 8'h77); m0[0] = 8'h77;
    expect_item(6, 0, 0, 16'h77);
    flush();

    // R9: short transfer reuses leftover bits, long transfer keeps last 13
    write_reg(4'h8, 8'hC3);
    spi_shift(64'b10101, 5);
    cs_release();
    m0[8] = 8'h75;
    expect_item(9, 0, 8, 16'h75);
    flush();
    spi_shift({48'h0, 3'b101, fr(1'b1, 4'h9, 8'h3C)}, 16);
    cs_release();
    m0[9] = 8'h3C;
    expect_item(9, 0, 9, 16'h3C);
    flush();

    // R7: two chained devices, separate words in one 26-bit transfer
    spi_shift({38'h0, fr(1'b1, 4'h2, 8'hB4), fr(1'b1, 4'h2, 8'h4B)}, 26);
    cs_release();
    m0[2] = 8'h4B;
    expect_item(7, 0, 2, 16'h4B);
    expect_item(7, 1, 2, 16'hB4);
    flush();
    spi_shift({38'h0, fr(1'b0, 4'h2, 8'h00), fr(1'b0, 4'h2, 8'h00)}, 26);
    cs_release();
    spi_shift(64'h0, 26);
    cs_release();
    rdw1 = got1[25:13];
    rdw0 = got1[12:0];
    expect_item(7, 1, 10, 16'(fr(1'b0, 4'h2, 8'hB4)));
    expect_item(7, 0, 10, 16'(fr(1'b0, 4'h2, 8'h4B)));
    flush();

    // R8: broadcast passes sdi through and both devices take one word
    bcast = 1'b1;
    sdi = 1'b1;
    wait_clk(2);
    expect_item(8, 1, 11, 16'h1);
    flush();
    sdi = 1'b0;
    wait_clk(2);
    expect_item(8, 1, 11, 16'h0);
    flush();
    spi_shift(64'(fr(1'b1, 4'h9, 8'h5A)), 13);
    cs_release();
    bcast = 1'b0;
    m0[9] = 8'h5A;
    expect_item(8, 0, 9, 16'h5A);
    expect_item(8, 1, 9, 16'h5A);
    expect_model(8);
    flush();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule